// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline

This block is a 32-bit in-order processor core split into five stages: fetch, decode with register read, ALU execute, data memory access and register write back. Four banks of pipeline registers sit between the stages, and every clock each bank takes over the outputs of the stage in front of it. A new instruction enters the pipe every cycle, so once the pipe has filled, one instruction leaves it per cycle. The core executes eight instructions: add, sub, and, or, slt, lw, sw and beq.

Instruction memory and data memory are separate arrays inside the core. Both use a synchronous read, so they map onto block RAM. A test environment fills them through one synchronous load port while reset is held. The core has no hazard detection, no forwarding and no squashing. The program has to be scheduled by hand: a consumer must sit at least three slots after its producer, and the three slots after a branch always execute. Each completing instruction is reported on a retire port with its PC and its register write, if any.

Reset clears every pipeline register to an empty slot and sets the PC to zero. It does not clear the general registers or the memories.

Top module: `pipe5_core`

## Requirements
- R1: While reset is high and on the first cycle after it, the retire strobe is low. The first instruction that retires after reset is the one at PC 0.
- R2: With reset released before clock edge 1, the first retire strobe appears after edge 4, which is the fifth cycle. No retire occurs after edges 1 to 3.
- R3: In straight-line code the core retires exactly one instruction per cycle, and each retired PC is 4 more than the one before.
- R4: R-type instructions (opcode 0x00, bits 10:6 zero) use the function field in bits 5:0: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than (result 1 or 0). Any other function code writes nothing.
- R5: The destination register is bits 15:11 for an R-type instruction and bits 20:16 for lw. The retire port reports the index that was actually written.
- R6: lw (opcode 0x23) and sw (opcode 0x2B) use the byte address rs (bits 25:21) plus the sign-extended 16-bit immediate. Negative offsets are allowed. A word stored by sw is returned by a later lw from the same address.
- R7: beq (opcode 0x04) is taken when rs equals rt, that is, when the ALU difference is zero. Its target is its PC + 4 + (sign-extended offset << 2). The PC is redirected when the beq is in the memory stage, so the three instructions after it still execute. A beq that is not taken does not disturb the PC sequence.
- R8: A register written in write back can be read in decode in the same cycle, so a consumer placed three slots after its producer gets the new value.
- R9: Writes to register 0 are discarded, and register 0 always reads as zero. An all-zero instruction word retires with no register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of PC and pipeline registers |
| load_en | input | 1 | Writes load_data into a memory word on this clock edge |
| load_dmem | input | 1 | Selects the memory to load: 0 = instruction memory, 1 = data memory |
| load_addr | input | LD_W (6) | Word index of the memory word to load |
| load_data | input | XLEN (32) | Word to load |
| retire_valid | output | 1 | An instruction completed write back this cycle |
| retire_pc | output | XLEN (32) | PC of the completing instruction |
| retire_wen | output | 1 | The completing instruction writes a register |
| retire_rd | output | RA_W (5) | Index of the register written |
| retire_wdata | output | XLEN (32) | Value written |

## Verification
The hardest case to reach is a taken branch, because the redirect takes effect three instructions late. The stimulus places three live arithmetic instructions in the shadow of a taken beq and puts a register write at the first address it skips. The retire stream must then show the three shadow instructions, jump straight to the target, and contain no trace of the skipped write. The same-cycle write-then-read case is reached by a consumer placed exactly three slots after a load. The loaded value differs from anything the register held before, so a stale read would show up as a wrong sum.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;
  localparam logic [5:0] OPC_BEQ   = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic    reg_write;
    logic    mem_read;
    logic    mem_write;
    logic    branch;
    logic    use_imm;
    logic    dst_rd;
    alu_op_e alu;
  } ctrl_t;

  function automatic ctrl_t decode_word(input logic [31:0] ir);
    ctrl_t c;
    c = '0;
    case (ir[31:26])
      OPC_RTYPE: begin
        if (ir[10:6] == 5'd0) begin
          c.dst_rd = 1'b1;
          c.reg_write = 1'b1;
          case (ir[5:0])
            FN_ADD:  c.alu = ALU_ADD;
            FN_SUB:  c.alu = ALU_SUB;
            FN_AND:  c.alu = ALU_AND;
            FN_OR:   c.alu = ALU_OR;
            FN_SLT:  c.alu = ALU_SLT;
            default: c.reg_write = 1'b0;
          endcase
        end
      end
      OPC_LOAD: begin
        c.reg_write = 1'b1;
        c.mem_read  = 1'b1;
        c.use_imm   = 1'b1;
      end
      OPC_STORE: begin
        c.mem_write = 1'b1;
        c.use_imm   = 1'b1;
      end
      OPC_BEQ: begin
        c.branch = 1'b1;
        c.alu    = ALU_SUB;
      end
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pipe5_sram.sv
module pipe5_sram #(
  parameter int WORDS = 64,
  parameter int W     = 32,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
  parameter int NREGS = 32,
  parameter int XLEN  = 32,
  localparam int RA_W = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [RA_W-1:0] waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [RA_W-1:0] ra1,
  input  logic [RA_W-1:0] ra2,
  output logic [XLEN-1:0] rd1,
  output logic [XLEN-1:0] rd2
);
  logic [XLEN-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (we && waddr != '0) regs[waddr] <= wdata;
  end

  // A write and a read of the same register in one cycle: the reader gets the new value.
  always_comb begin
    if (ra1 == '0)                  rd1 = '0;
    else if (we && waddr == ra1)    rd1 = wdata;
    else                            rd1 = regs[ra1];
    if (ra2 == '0)                  rd2 = '0;
    else if (we && waddr == ra2)    rd2 = wdata;
    else                            rd2 = regs[ra2];
  end
endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
  import pipe5_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_op_e         op,
  output logic [XLEN-1:0] y,
  output logic            zero
);
  always_comb begin
    case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = ($signed(a) < $signed(b)) ? XLEN'(1) : '0;
      default: y = a + b;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int NREGS      = 32,
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int RA_W = $clog2(NREGS),
  localparam int IA_W = $clog2(IMEM_WORDS),
  localparam int DA_W = $clog2(DMEM_WORDS),
  localparam int LD_W = (IA_W > DA_W) ? IA_W : DA_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_en,
  input  logic            load_dmem,
  input  logic [LD_W-1:0] load_addr,
  input  logic [XLEN-1:0] load_data,
  output logic            retire_valid,
  output logic [XLEN-1:0] retire_pc,
  output logic            retire_wen,
  output logic [RA_W-1:0] retire_rd,
  output logic [XLEN-1:0] retire_wdata
);
  // fetch
  logic [XLEN-1:0] pc_q;
  logic            redirect;
  logic [XLEN-1:0] ir_raw;
  // IF/ID
  logic            id_valid;
  logic [XLEN-1:0] id_pc;
  logic [XLEN-1:0] id_ir;
  ctrl_t           id_ctrl;
  logic [XLEN-1:0] id_a, id_b, id_imm;
  // ID/EX
  logic            ex_valid;
  logic [XLEN-1:0] ex_pc, ex_a, ex_b, ex_imm;
  ctrl_t           ex_ctrl;
  logic [RA_W-1:0] ex_rt, ex_rd, ex_dst;
  logic [XLEN-1:0] ex_y;
  logic            ex_zero;
  // EX/MEM
  logic            mem_valid;
  logic [XLEN-1:0] mem_pc, mem_y, mem_b, mem_target;
  ctrl_t           mem_ctrl;
  logic            mem_zero;
  logic [RA_W-1:0] mem_dst;
  logic [XLEN-1:0] dm_rdata;
  // MEM/WB
  logic            wb_valid, wb_wen, wb_from_mem;
  logic [XLEN-1:0] wb_pc, wb_y, wb_data;
  logic [RA_W-1:0] wb_dst;

  // ---------------- IF ----------------
  assign redirect = mem_valid && mem_ctrl.branch && mem_zero;

  always_ff @(posedge clk) begin
    if (rst)           pc_q <= '0;
    else if (redirect) pc_q <= mem_target;
    else               pc_q <= pc_q + XLEN'(4);
  end

  pipe5_sram #(.WORDS(IMEM_WORDS), .W(XLEN)) u_imem (
    .clk(clk), .we(load_en && !load_dmem), .waddr(load_addr[IA_W-1:0]),
    .wdata(load_data), .raddr(pc_q[IA_W+1:2]), .rdata(ir_raw)
  );

  // The read register of the instruction memory serves as the IF/ID instruction register.
  always_ff @(posedge clk) begin
    if (rst) begin
      id_valid <= 1'b0;
      id_pc    <= '0;
    end else begin
      id_valid <= 1'b1;
      id_pc    <= pc_q;
    end
  end

  // ---------------- ID ----------------
  assign id_ir   = id_valid ? ir_raw : '0;
  assign id_ctrl = decode_word(id_ir);
  assign id_imm  = {{(XLEN-16){id_ir[15]}}, id_ir[15:0]};

  pipe5_regfile #(.NREGS(NREGS), .XLEN(XLEN)) u_rf (
    .clk(clk), .we(wb_wen), .waddr(wb_dst), .wdata(wb_data),
    .ra1(id_ir[21 +: RA_W]), .ra2(id_ir[16 +: RA_W]), .rd1(id_a), .rd2(id_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_valid <= 1'b0;
      ex_ctrl  <= '0;
      ex_pc    <= '0;
      ex_a     <= '0;
      ex_b     <= '0;
      ex_imm   <= '0;
      ex_rt    <= '0;
      ex_rd    <= '0;
    end else begin
      ex_valid <= id_valid;
      ex_ctrl  <= id_ctrl;
      ex_pc    <= id_pc;
      ex_a     <= id_a;
      ex_b     <= id_b;
      ex_imm   <= id_imm;
      ex_rt    <= id_ir[16 +: RA_W];
      ex_rd    <= id_ir[11 +: RA_W];
    end
  end

  // ---------------- EX ----------------
  pipe5_alu #(.XLEN(XLEN)) u_alu (
    .a(ex_a), .b(ex_ctrl.use_imm ? ex_imm : ex_b), .op(ex_ctrl.alu),
    .y(ex_y), .zero(ex_zero)
  );
  assign ex_dst = ex_ctrl.dst_rd ? ex_rd : ex_rt;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_valid  <= 1'b0;
      mem_ctrl   <= '0;
      mem_pc     <= '0;
      mem_y      <= '0;
      mem_zero   <= 1'b0;
      mem_b      <= '0;
      mem_dst    <= '0;
      mem_target <= '0;
    end else begin
      mem_valid  <= ex_valid;
      mem_ctrl   <= ex_ctrl;
      mem_pc     <= ex_pc;
      mem_y      <= ex_y;
      mem_zero   <= ex_zero;
      mem_b      <= ex_b;
      mem_dst    <= ex_dst;
      mem_target <= ex_pc + XLEN'(4) + (ex_imm << 2);
    end
  end

  // ---------------- MEM ----------------
  logic            dm_we;
  logic [DA_W-1:0] dm_waddr;
  logic [XLEN-1:0] dm_wdata;

  always_comb begin
    if (load_en && load_dmem) begin
      dm_we    = 1'b1;
      dm_waddr = load_addr[DA_W-1:0];
      dm_wdata = load_data;
    end else begin
      dm_we    = mem_valid && mem_ctrl.mem_write;
      dm_waddr = mem_y[DA_W+1:2];
      dm_wdata = mem_b;
    end
  end

  pipe5_sram #(.WORDS(DMEM_WORDS), .W(XLEN)) u_dmem (
    .clk(clk), .we(dm_we), .waddr(dm_waddr), .wdata(dm_wdata),
    .raddr(mem_y[DA_W+1:2]), .rdata(dm_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid    <= 1'b0;
      wb_wen      <= 1'b0;
      wb_from_mem <= 1'b0;
      wb_pc       <= '0;
      wb_y        <= '0;
      wb_dst      <= '0;
    end else begin
      wb_valid    <= mem_valid;
      wb_wen      <= mem_valid && mem_ctrl.reg_write && (mem_dst != '0);
      wb_from_mem <= mem_ctrl.mem_read;
      wb_pc       <= mem_pc;
      wb_y        <= mem_y;
      wb_dst      <= mem_dst;
    end
  end

  // ---------------- WB ----------------
  assign wb_data      = wb_from_mem ? dm_rdata : wb_y;
  assign retire_valid = wb_valid;
  assign retire_pc    = wb_pc;
  assign retire_wen   = wb_wen;
  assign retire_rd    = wb_dst;
  assign retire_wdata = wb_data;
endmodule

// File: rtl/pipe5_checker.sv
module pipe5_checker #(
  parameter int XLEN = 32,
  parameter int RA_W = 5
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] pc_q,
  input logic            redirect,
  input logic [XLEN-1:0] mem_target,
  input logic            retire_valid,
  input logic            retire_wen,
  input logic [RA_W-1:0] retire_rd
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!retire_valid && pc_q == '0));

  assert_first_retire_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(retire_valid) |-> ($past(rst, 5) && !$past(rst, 4)));

  assert_pc_step_R3: assert property (@(posedge clk) disable iff (rst)
    !redirect |=> pc_q == $past(pc_q) + XLEN'(4));

  assert_branch_target_R7: assert property (@(posedge clk) disable iff (rst)
    redirect |=> pc_q == $past(mem_target));

  assert_no_r0_write_R9: assert property (@(posedge clk) disable iff (rst)
    retire_wen |-> (retire_valid && retire_rd != '0));
endmodule

bind pipe5_core pipe5_checker #(.XLEN(XLEN), .RA_W(RA_W)) u_chk (
  .clk(clk), .rst(rst), .pc_q(pc_q), .redirect(redirect),
  .mem_target(mem_target), .retire_valid(retire_valid),
  .retire_wen(retire_wen), .retire_rd(retire_rd)
);

// File: tb/tb_pipe5_core.sv
module tb_pipe5_core;
  localparam int WORDS = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_en = 1'b0;
  logic        load_dmem = 1'b0;
  logic [5:0]  load_addr = '0;
  logic [31:0] load_data = '0;
  logic        retire_valid, retire_wen;
  logic [31:0] retire_pc, retire_wdata;
  logic [4:0]  retire_rd;

  pipe5_core dut (
    .clk(clk), .rst(rst), .load_en(load_en), .load_dmem(load_dmem),
    .load_addr(load_addr), .load_data(load_data),
    .retire_valid(retire_valid), .retire_pc(retire_pc), .retire_wen(retire_wen),
    .retire_rd(retire_rd), .retire_wdata(retire_wdata)
  );

  always #4 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [31:0] prog [WORDS];
  logic [31:0] lg_pc [WORDS];
  logic        lg_wen [WORDS];
  logic [4:0]  lg_rd [WORDS];
  logic [31:0] lg_dat [WORDS];
  int          lg_cyc [WORDS];
  int          nlog;
  int          early_retire;

  function automatic logic [31:0] rop(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] iop(input logic [5:0] op, input int rs, input int rt, input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < WORDS; i++) prog[i] = 32'h0;
  endtask

  task automatic load_word(input bit dsel, input int addr, input logic [31:0] val);
    @(negedge clk);
    load_en = 1'b1; load_dmem = dsel; load_addr = 6'(addr); load_data = val;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  // Holds reset, fills instruction memory, then runs ncyc clocks and logs retires.
  task automatic run_prog(input int ncyc);
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < WORDS; i++) load_word(1'b0, i, prog[i]);
    @(negedge clk);
    rst = 1'b0;
    nlog = 0;
    early_retire = 0;
    for (int c = 1; c <= ncyc; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (retire_valid) begin
        if (c < 4) early_retire++;
        if (nlog < WORDS) begin
          lg_pc[nlog] = retire_pc; lg_wen[nlog] = retire_wen; lg_rd[nlog] = retire_rd;
          lg_dat[nlog] = retire_wdata; lg_cyc[nlog] = c;
          nlog++;
        end
      end
    end
  endtask

  task automatic chk_ret(input int k, input logic [31:0] pc, input bit wen,
                         input int rd, input logic [31:0] dat, input string req);
    check(k < nlog, req, "retire entry present", 32'(nlog), 32'(k + 1));
    if (k < nlog) begin
      check(lg_pc[k] == pc, req, "retired pc", lg_pc[k], pc);
      check(lg_wen[k] == wen, req, "retire write enable", 32'(lg_wen[k]), 32'(wen));
      if (wen) begin
        check(lg_rd[k] == 5'(rd), req, "destination index", 32'(lg_rd[k]), 32'(rd));
        check(lg_dat[k] == dat, req, "written value", lg_dat[k], dat);
      end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(retire_valid == 1'b0, "R1", "retire strobe during reset", 32'(retire_valid), 32'd0);
  endtask

  task automatic t_alu_mem();
    load_word(1'b1, 0, 32'd7);
    load_word(1'b1, 1, 32'hFFFF_FFFD);
    load_word(1'b1, 2, 32'h0F0F_00FF);
    load_word(1'b1, 3, 32'd24);
    load_word(1'b1, 4, 32'hDEAD_BEEF);
    clear_prog();
    prog[0]  = iop(pipe5_pkg::OPC_LOAD, 0, 1, 0);
    prog[1]  = iop(pipe5_pkg::OPC_LOAD, 0, 2, 4);
    prog[2]  = iop(pipe5_pkg::OPC_LOAD, 0, 3, 8);
    prog[3]  = iop(pipe5_pkg::OPC_LOAD, 0, 13, 12);
    prog[5]  = rop(1, 2, 4, pipe5_pkg::FN_ADD);
    prog[6]  = rop(1, 2, 5, pipe5_pkg::FN_SUB);
    prog[7]  = rop(3, 1, 6, pipe5_pkg::FN_AND);
    prog[8]  = rop(3, 2, 7, pipe5_pkg::FN_OR);
    prog[9]  = rop(2, 1, 8, pipe5_pkg::FN_SLT);
    prog[10] = rop(1, 2, 9, pipe5_pkg::FN_SLT);
    prog[11] = iop(pipe5_pkg::OPC_STORE, 0, 4, 16);
    prog[12] = iop(pipe5_pkg::OPC_LOAD, 0, 10, 16);
    prog[13] = iop(pipe5_pkg::OPC_LOAD, 13, 11, -16);
    prog[14] = rop(1, 1, 0, pipe5_pkg::FN_ADD);
    prog[16] = rop(4, 0, 15, pipe5_pkg::FN_OR);
    prog[17] = rop(1, 1, 16, 6'h3F);
    run_prog(26);
    check(early_retire == 0, "R2", "retire before cycle five", 32'(early_retire), 32'd0);
    check(nlog > 0 && lg_cyc[0] == 4, "R2", "edge of first retire", 32'(lg_cyc[0]), 32'd4);
    check(nlog > 0 && lg_pc[0] == 32'd0, "R1", "first retired pc", lg_pc[0], 32'd0);
    for (int k = 0; k < 18; k++) begin
      check(k < nlog && lg_cyc[k] == 4 + k && lg_pc[k] == 32'(4 * k), "R3",
            "one retire per cycle, pc step", lg_pc[k], 32'(4 * k));
    end
    chk_ret(0, 0, 1, 1, 32'd7, "R5");
    chk_ret(1, 4, 1, 2, 32'hFFFF_FFFD, "R5");
    chk_ret(2, 8, 1, 3, 32'h0F0F_00FF, "R6");
    chk_ret(4, 16, 0, 0, 0, "R9");
    chk_ret(5, 20, 1, 4, 32'd4, "R4");
    chk_ret(6, 24, 1, 5, 32'd10, "R4");
    chk_ret(7, 28, 1, 6, 32'd7, "R4");
    chk_ret(8, 32, 1, 7, 32'hFFFF_FFFF, "R4");
    chk_ret(9, 36, 1, 8, 32'd1, "R4");
    chk_ret(10, 40, 1, 9, 32'd0, "R4");
    chk_ret(11, 44, 0, 0, 0, "R6");
    chk_ret(12, 48, 1, 10, 32'd4, "R6");
    chk_ret(13, 52, 1, 11, 32'h0F0F_00FF, "R6");
    chk_ret(14, 56, 0, 0, 0, "R9");
    chk_ret(16, 64, 1, 15, 32'd4, "R9");
    chk_ret(17, 68, 0, 0, 0, "R4");
  endtask

  task automatic t_bypass();
    load_word(1'b1, 0, 32'd100);
    clear_prog();
    prog[0] = iop(pipe5_pkg::OPC_LOAD, 0, 1, 0);
    prog[3] = rop(1, 1, 2, pipe5_pkg::FN_ADD);
    prog[6] = rop(2, 1, 3, pipe5_pkg::FN_SUB);
    run_prog(14);
    chk_ret(0, 0, 1, 1, 32'd100, "R8");
    chk_ret(3, 12, 1, 2, 32'd200, "R8");
    chk_ret(6, 24, 1, 3, 32'd100, "R8");
  endtask

  task automatic t_branch();
    load_word(1'b1, 0, 32'd5);
    clear_prog();
    prog[0]  = iop(pipe5_pkg::OPC_LOAD, 0, 1, 0);
    prog[1]  = iop(pipe5_pkg::OPC_LOAD, 0, 2, 0);
    prog[4]  = iop(pipe5_pkg::OPC_BEQ, 1, 2, 6);
    prog[5]  = rop(1, 1, 3, pipe5_pkg::FN_ADD);
    prog[6]  = rop(1, 2, 4, pipe5_pkg::FN_ADD);
    prog[7]  = rop(2, 2, 5, pipe5_pkg::FN_ADD);
    prog[8]  = rop(1, 1, 6, pipe5_pkg::FN_ADD);
    prog[11] = rop(1, 1, 7, pipe5_pkg::FN_ADD);
    prog[12] = iop(pipe5_pkg::OPC_BEQ, 1, 0, 4);
    prog[13] = rop(1, 0, 8, pipe5_pkg::FN_OR);
    run_prog(20);
    chk_ret(4, 16, 0, 0, 0, "R7");
    chk_ret(5, 20, 1, 3, 32'd10, "R7");
    chk_ret(6, 24, 1, 4, 32'd10, "R7");
    chk_ret(7, 28, 1, 5, 32'd10, "R7");
    chk_ret(8, 44, 1, 7, 32'd10, "R7");
    chk_ret(9, 48, 0, 0, 0, "R7");
    chk_ret(10, 52, 1, 8, 32'd5, "R7");
    check(nlog > 8 && lg_cyc[8] == lg_cyc[7] + 1, "R7", "no gap at redirect",
          32'(lg_cyc[8]), 32'(lg_cyc[7] + 1));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_alu_mem();
    t_bypass();
    t_branch();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule